// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block is a supervisory timer for a processor subsystem. A 24-bit down-counter loses one count for every four pulses of a watchdog tick input, through a fixed divide-by-four stage. Software must refresh it in time with a two-write key sequence on a small register port. If the counter runs out, the block raises a reset request. The same happens when the refresh is malformed, or when it arrives while the count is still above a programmable window ceiling.

A 10-bit compare value raises a warning interrupt shortly before expiry. This gives software a last chance to react. An optional lock keeps the reload value read-only until the counter has fallen to that warning level.

The enable bit cannot be cleared once set. The counter stays idle at all-ones until the first good refresh after enabling. The reset request and the time-out flag are held until the block's own reset input.

Register map, on `bus_addr`:

| Address | Register | Content |
|---|---|---|
| 0 | control | bit0 enable, bit1 reload lock, bit2 warning flag, bit3 time-out flag |
| 1 | reload | 24-bit reload value |
| 2 | feed | key writes; reads return 0 |
| 3 | count | current count, read only |
| 4 | warning compare | 10-bit compare value |
| 5 | window ceiling | 24-bit ceiling |

Top module: `wdog_window`

## Requirements
- R1: After reset, `rst_req` and `warn_irq` are 0. The control register reads 0, the count and the window ceiling read 0xFFFFFF, the reload reads 0x0000FF and the warning compare reads 0.
- R2: Writing 1 to control bit0 enables the watchdog. A later write of 0 to that bit leaves it set.
- R3: A good feed is a write of low byte 0xAA to address 2, with the very next bus access being a write of low byte 0x55 to address 2. While enabled, a good feed loads the count from the reload register. Before the first good feed after enabling, or while disabled, the count stays at 0xFFFFFF.
- R4: Once started, the count falls by exactly one on every fourth cycle that has `tick_en` high. Counting of tick cycles restarts from zero at every load.
- R5: The reload register stores a written value below 0xFF as 0xFF. When a decrement step occurs at count 0, `rst_req` and control bit3 (time-out flag) are set in the following cycle. A load of value N therefore expires after N+1 steps.
- R6: While enabled, any malformed feed sets `rst_req` on the next cycle. This covers a data byte other than 0xAA at the start, or any access other than the 0x55 write right after 0xAA. While disabled, such accesses have no effect.
- R7: While the counter runs, a good feed that arrives when the count is above the window ceiling (address 5) sets `rst_req`. A good feed at or below the ceiling reloads without a reset request.
- R8: When a step brings the count to the value of the warning compare (address 4, upper 14 bits taken as zero), control bit2 and `warn_irq` go to 1. Writing 1 to control bit2 clears them.
- R9: With control bit1 (reload lock) set, a write to the reload register is dropped unless the counter is running and the count is at or below the warning compare value.
- R10: Once set, `rst_req` and the time-out flag stay at 1 until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One watchdog clock pulse per cycle it is high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data for `bus_addr` |
| rst_req | output | 1 | Sticky reset request |
| warn_irq | output | 1 | Warning interrupt, level |

## Verification
A wrong prescaler phase or a missed decrement is visible through the count register within four ticks. It also moves the cycle in which `warn_irq` and `rst_req` rise, and the per-cycle comparison catches that on the exact cycle. A stale feed-key state shows up as a reset request one cycle after the access that should have been accepted or rejected. A broken sticky bit shows up as a control read that differs right after the clearing write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W      = 24;
  localparam int WARN_W     = 10;
  localparam int PRE_DIV    = 4;
  localparam int ADDR_W     = 3;
  localparam int MIN_RELOAD = 255;
  localparam int KEY_W      = 8;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [WARN_W-1:0] warn_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [KEY_W-1:0]  key_t;

  localparam addr_t A_CTRL   = addr_t'(0);
  localparam addr_t A_RELOAD = addr_t'(1);
  localparam addr_t A_FEED   = addr_t'(2);
  localparam addr_t A_COUNT  = addr_t'(3);
  localparam addr_t A_WARN   = addr_t'(4);
  localparam addr_t A_WINDOW = addr_t'(5);

  localparam key_t KEY_OPEN  = key_t'(8'hAA);
  localparam key_t KEY_CLOSE = key_t'(8'h55);

  function automatic cnt_t clamp_reload(cnt_t v);
    return (v < cnt_t'(MIN_RELOAD)) ? cnt_t'(MIN_RELOAD) : v;
  endfunction

  function automatic logic above_window(cnt_t c, cnt_t ceiling);
    return c > ceiling;
  endfunction

  function automatic logic steps_onto(cnt_t c, warn_t w);
    return (c - cnt_t'(1)) == cnt_t'(w);
  endfunction

  function automatic logic at_or_below(cnt_t c, warn_t w);
    return c <= cnt_t'(w);
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale
  import wdog_pkg::*;
#(
  parameter int DIV = PRE_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic step
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] phase_q;
  logic          last_phase;

  assign last_phase = (phase_q == PW'(DIV - 1));
  assign step       = run && !restart && tick && last_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase_q <= '0;
    else if (!run || restart)  phase_q <= '0;
    else if (tick)             phase_q <= last_phase ? '0 : phase_q + PW'(1);
  end

  // R4: steps are spaced by at least DIV tick cycles
  a_r4_step_gap: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);
endmodule

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic rd,
  input  logic at_feed,
  input  key_t key,
  output logic good,
  output logic bad
);
  logic armed_q;
  logic access;
  logic opens;

  assign access = wr || rd;
  assign opens  = wr && at_feed && (key == KEY_OPEN);
  assign good   = armed_q && wr && at_feed && (key == KEY_CLOSE);

  always_comb begin
    bad = 1'b0;
    if (access) begin
      if (armed_q) bad = !good;
      else         bad = wr && at_feed && !opens;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (access) armed_q <= !armed_q && opens;
  end

  // R3: an armed sequence is resolved by the very next access
  a_r3_arm_resolves: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && access) |=> !armed_q);
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  cnt_t  load_val,
  input  logic  step,
  input  warn_t warn_cmp,
  output cnt_t  count,
  output logic  running,
  output logic  expire,
  output logic  warn_hit
);
  assign expire   = step && !load && (count == '0);
  assign warn_hit = step && !load && (count != '0) && steps_onto(count, warn_cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '1;
      running <= 1'b0;
    end else if (load) begin
      count   <= load_val;
      running <= 1'b1;
    end else if (step && count != '0) begin
      count   <= count - cnt_t'(1);
    end
  end

  // R4: a step away from zero removes exactly one count
  a_r4_one_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && count != '0) |=> (count == $past(count) - cnt_t'(1)));
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              rst_req,
  output logic              warn_irq
);
  logic  en_q, lock_q, warnf_q, tof_q, req_q;
  cnt_t  reload_q, window_q;
  warn_t warn_q;

  logic  feed_good, feed_bad, feed_load, window_bad;
  logic  step, expire, warn_hit, running, req_set;
  logic  ctrl_wr, reload_wr_ok;
  cnt_t  count;

  wdog_feed_seq u_feed (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .at_feed (bus_addr == A_FEED),
    .key     (bus_wdata[KEY_W-1:0]),
    .good    (feed_good),
    .bad     (feed_bad)
  );

  assign window_bad = feed_good && en_q && running && above_window(count, window_q);
  assign feed_load  = feed_good && en_q && !window_bad;

  wdog_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .restart (feed_load),
    .tick    (tick_en),
    .step    (step)
  );

  wdog_count u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (feed_load),
    .load_val (reload_q),
    .step     (step),
    .warn_cmp (warn_q),
    .count    (count),
    .running  (running),
    .expire   (expire),
    .warn_hit (warn_hit)
  );

  assign ctrl_wr      = bus_wr && (bus_addr == A_CTRL);
  assign reload_wr_ok = bus_wr && (bus_addr == A_RELOAD) &&
                        (!lock_q || (running && at_or_below(count, warn_q)));
  assign req_set      = expire || (en_q && (feed_bad || window_bad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      lock_q   <= 1'b0;
      warnf_q  <= 1'b0;
      tof_q    <= 1'b0;
      req_q    <= 1'b0;
      reload_q <= cnt_t'(MIN_RELOAD);
      window_q <= '1;
      warn_q   <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= en_q | bus_wdata[0];
        lock_q <= bus_wdata[1];
      end
      if (warn_hit)                   warnf_q <= 1'b1;
      else if (ctrl_wr && bus_wdata[2]) warnf_q <= 1'b0;
      if (expire)  tof_q <= 1'b1;
      if (req_set) req_q <= 1'b1;
      if (reload_wr_ok) reload_q <= clamp_reload(bus_wdata);
      if (bus_wr && bus_addr == A_WINDOW) window_q <= bus_wdata;
      if (bus_wr && bus_addr == A_WARN)   warn_q   <= bus_wdata[WARN_W-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:   bus_rdata = cnt_t'({tof_q, warnf_q, lock_q, en_q});
      A_RELOAD: bus_rdata = reload_q;
      A_COUNT:  bus_rdata = count;
      A_WARN:   bus_rdata = cnt_t'(warn_q);
      A_WINDOW: bus_rdata = window_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign rst_req  = req_q;
  assign warn_irq = warnf_q;

  // R2: enable cannot fall without rst_n
  a_r2_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
  // R10: reset request is held
  a_r10_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  // R6: malformed feed while enabled requests reset
  a_r6_bad_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_bad && en_q) |=> rst_req);
  // R5: expiry sets both request and time-out flag
  a_r5_expire_flags: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (rst_req && tof_q));
  // R8: reaching the warning level raises the interrupt
  a_r8_warn_irq: assert property (@(posedge clk) disable iff (!rst_n)
    warn_hit |=> warn_irq);
  // R3: counter holds all-ones until started
  a_r3_idle_full: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (count == '1));
  // R7: early feed while running requests reset
  a_r7_early_feed: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_good && en_q && running && count > window_q) |=> rst_req);
endmodule

// File: tb/wdog_window_tb_top.sv
module wdog_window_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [23:0] bus_wdata = 24'd0;
  logic [23:0] bus_rdata;
  logic        rst_req, warn_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_window dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .warn_irq(warn_irq)
  );

  // behavioural reference model
  bit m_en, m_lock, m_wf, m_to, m_req, m_run, m_armed;
  int m_cnt, m_pre, m_reload, m_win, m_warn;

  function automatic int m_read(int a);
    case (a)
      0: return (m_to << 3) | (m_wf << 2) | (m_lock << 1) | int'(m_en);
      1: return m_reload;
      3: return m_cnt;
      4: return m_warn;
      5: return m_win;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_lock = 0; m_wf = 0; m_to = 0; m_req = 0; m_run = 0; m_armed = 0;
      m_cnt = 24'hFFFFFF; m_pre = 0; m_reload = 255; m_win = 24'hFFFFFF; m_warn = 0;
    end else begin
      bit ok, bad, stp, early, wf_set, clr;
      int a, d, lo;
      a = int'(bus_addr); d = int'(bus_wdata); lo = d & 255;
      ok = 0; bad = 0; wf_set = 0;
      stp = m_run && tick_en && (m_pre == 3);
      if (bus_wr || bus_rd) begin
        if (m_armed) begin
          ok = bus_wr && a == 2 && lo == 8'h55;
          bad = !ok;
          m_armed = 0;
        end else if (bus_wr && a == 2) begin
          if (lo == 8'hAA) m_armed = 1; else bad = 1;
        end
      end
      early = ok && m_en && m_run && (m_cnt > m_win);
      clr = bus_wr && a == 0 && d[2];
      if (m_en && (bad || early)) m_req = 1;
      if (bus_wr && a == 1 && (!m_lock || (m_run && m_cnt <= m_warn)))
        m_reload = (d < 255) ? 255 : d;
      if (ok && m_en && !early) begin
        m_cnt = m_reload; m_run = 1; m_pre = 0;
      end else begin
        if (m_run && tick_en) m_pre = (m_pre + 1) % 4;
        if (stp) begin
          if (m_cnt == 0) begin m_to = 1; m_req = 1; end
          else begin
            m_cnt = m_cnt - 1;
            if (m_cnt == m_warn) wf_set = 1;
          end
        end
      end
      if (bus_wr && a == 0) begin
        m_en = m_en | d[0];
        m_lock = d[1];
      end
      if (wf_set) m_wf = 1; else if (clr) m_wf = 0;
      if (bus_wr && a == 5) m_win = d;
      if (bus_wr && a == 4) m_warn = d & 1023;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison of the outputs against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 rst_req vs model", int'(rst_req), int'(m_req));
      check("R8 warn_irq vs model", int'(warn_irq), int'(m_wf));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R1 watchdog actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 3'(a); bus_wdata = 24'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int a, string req, int exp);
    @(negedge clk);
    bus_rd = 1; bus_addr = 3'(a);
    #1;
    check(req, int'(bus_rdata), exp);
    check({req, " model"}, int'(bus_rdata), m_read(a));
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic feed();
    wr(2, 8'hAA);
    wr(2, 8'h55);
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  initial begin
    do_reset();
    // R1 reset values
    rd(0, "R1 ctrl", 0);
    rd(3, "R1 count", 24'hFFFFFF);
    rd(5, "R1 window", 24'hFFFFFF);
    rd(1, "R1 reload", 24'hFF);
    rd(4, "R1 warn", 0);
    check("R1 rst_req", int'(rst_req), 0);

    // disabled: feeds and bad keys do nothing
    feed();
    rd(3, "R3 idle while disabled", 24'hFFFFFF);
    wr(2, 8'h12);
    check("R6 bad key while disabled", int'(rst_req), 0);

    // R2 sticky enable
    wr(0, 1);
    wr(0, 0);
    rd(0, "R2 enable held", 1);
    rd(3, "R3 idle before first feed", 24'hFFFFFF);

    // R5 clamp, R3 load, R4 divide
    wr(1, 24'h10);
    rd(1, "R5 reload clamped", 24'hFF);
    wr(1, 24'h100);
    feed();
    rd(3, "R3 loaded", 24'h100);
    ticks(8);
    rd(3, "R4 two steps", 24'hFE);
    ticks(1016);
    rd(3, "R5 reached zero", 0);
    check("R5 no request yet", int'(rst_req), 0);
    ticks(4);
    check("R5 request on expiry", int'(rst_req), 1);
    rd(0, "R5 timeout flag", 24'hD);
    wr(0, 24'h4);
    ticks(20);
    check("R10 request held", int'(rst_req), 1);
    rd(0, "R10 timeout flag held", 24'h9);

    // R6 interrupted sequence
    do_reset();
    check("R10 cleared by rst_n", int'(rst_req), 0);
    wr(0, 1);
    feed();
    wr(2, 8'hAA);
    rd(0, "R6 ctrl read", 1);
    check("R6 interrupted feed", int'(rst_req), 1);

    // R7 early feed
    do_reset();
    wr(0, 1);
    wr(5, 24'h80);
    feed();
    check("R7 first feed ok", int'(rst_req), 0);
    feed();
    check("R7 early feed", int'(rst_req), 1);

    do_reset();
    wr(0, 1);
    wr(5, 24'h80);
    feed();
    ticks(4 * 8'h80);
    rd(3, "R7 inside window", 24'h7F);
    feed();
    check("R7 feed in window", int'(rst_req), 0);
    rd(3, "R7 reloaded", 24'hFF);

    // R8 warning
    do_reset();
    wr(4, 24'hF0);
    wr(0, 1);
    feed();
    ticks(56);
    rd(3, "R8 before warning", 24'hF1);
    check("R8 no irq yet", int'(warn_irq), 0);
    ticks(4);
    check("R8 irq raised", int'(warn_irq), 1);
    rd(0, "R8 flag bit", 24'h5);
    wr(0, 24'h5);
    check("R8 irq cleared", int'(warn_irq), 0);

    // R9 reload lock
    do_reset();
    wr(4, 24'h20);
    wr(0, 3);
    wr(1, 24'h300);
    rd(1, "R9 locked reload", 24'hFF);
    feed();
    ticks(4 * 8'hDF);
    rd(3, "R9 at warning level", 24'h20);
    wr(1, 24'h300);
    rd(1, "R9 unlocked reload", 24'h300);
    feed();
    rd(3, "R9 new reload used", 24'h300);
    check("R9 no request", int'(rst_req), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule